// File: doc/BRIEF.md
# Programmable Parallel I/O Interface

A processor-attached parallel I/O controller with three 8-bit ports, A, B and C. The host reaches it through a synchronous, demultiplexed 8-bit data bus with a 2-bit address, a chip select and single-cycle read and write strobes. A control register sets the operating mode and the directions of two groups. The first group is port A with port C bits 7..4. The second group is port B with port C bits 3..0. Each port pin is presented as an input, a latched output and an output enable, so the tristate pads stay outside the block.

Group A runs plain I/O (mode 0), strobed handshake I/O (mode 1) or bidirectional handshake I/O (mode 2). Group B runs mode 0 or mode 1. In the handshake modes some port C lines become strobe, acknowledge, buffer-full and interrupt lines. A read of port C then returns that status, and each interrupt-enable bit appears at its strobe or acknowledge position. Handshake inputs on port C pass through `SYNC_STAGES` flops before use. With the default of 0, they act at the next clock edge.

Top module: `ppio_top`

## Requirements
- R1: After reset, the control readback at address 3 is 0x9B (all groups in mode 0, all ports input), every output enable is 0, and pa_out and pb_out are 0.
- R2: Addresses 0, 1 and 2 select ports A, B and C, and address 3 selects control. A write to address 3 with bit 7 set loads the mode word: bits 6..5 set the group A mode (00 = mode 0, 01 = mode 1, 1x = mode 2), bit 4 sets port A input, bit 3 sets port C upper input, bit 2 sets the group B mode (0 = mode 0, 1 = mode 1), bit 1 sets port B input and bit 0 sets port C lower input. Reading address 3 returns bit 7 as 1 with the stored word in bits 6..0.
- R3: Loading a mode word clears the port A, B and C output latches, all buffer-full and interrupt flags, and all interrupt enables.
- R4: A write to address 3 with bit 7 clear sets port C bit wdata[3:1] to wdata[0] and the interrupt enable held at that position. It leaves the control word unchanged.
- R5: In mode 0, an output port drives its latch with the enable at all ones. An input port has the enable at 0 and reads the current pin value without latching. The two port C nibbles follow their own direction bits.
- R6: For a mode 1 input port, the strobe (port A: PC4, port B: PC2) low latches the pin data and sets input-buffer-full (port A: PC5, port B: PC1, driven high). Later pin changes do not alter the value that is read.
- R7: For a mode 1 input port, the strobe returning high while input-buffer-full and the enable are set raises the interrupt (port A: PC3, port B: PC0) one cycle later. A host read of the port clears both the interrupt and input-buffer-full. With the enable clear, no interrupt is raised.
- R8: For a mode 1 output port, a host write drives output-buffer-full low (port A: PC7, port B: PC1) and clears the interrupt. The acknowledge (port A: PC6, port B: PC2) low sets output-buffer-full high again. The acknowledge returning high raises the interrupt when the enable is set.
- R9: In handshake modes, port C pins that are not used for handshake keep working as plain I/O in their nibble. Handshake outputs are always enabled, and handshake inputs are never driven.
- R10: In mode 2, port A outputs are enabled only while PC6 is low. PC4 latches the input data, PC5 and PC7 report the two buffer states, PC3 is the OR of both interrupts, and PC6 and PC4 read back the output and input enables.
- R11: Group B runs mode 1 on PC2..PC0 while group A runs mode 2.
- R12: When a host read of a port falls in the same cycle as its strobe rising, no interrupt is raised. When a host write falls in the same cycle as the acknowledge being low, output-buffer-full stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Single-cycle read strobe |
| wr | input | 1 | Single-cycle write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational for the addressed register |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A pin output value |
| pa_oe | output | 8 | Port A output enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B pin output value |
| pb_oe | output | 8 | Port B output enable |
| pc_in | input | 8 | Port C pin input, including strobes and acknowledges |
| pc_out | output | 8 | Port C pin output value, including handshake status |
| pc_oe | output | 8 | Port C output enable |

## Verification
Host accesses can land in the same cycle as a peripheral handshake edge. There are two such cases: a port read meeting the strobe's rising edge, and a port write meeting a low acknowledge. The bench starts both events at the same falling clock edge, so they reach the same rising edge. It then judges the result one cycle later at the port C status pins. The interrupt must stay low after the read, and output-buffer-full must stay low after the write. A sweep over all sixteen mode 0 direction combinations checks the enables, latches and pass-through reads against values computed from the direction bits.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
   localparam int PORT_W = 8;

   typedef struct packed {
      logic [1:0] a_mode;
      logic       a_in;
      logic       cu_in;
      logic       b_mode;
      logic       b_in;
      logic       cl_in;
   } ctl_t;

   localparam ctl_t CTL_RESET = 7'b00_1_1_0_1_1;

   localparam int PC_INTR_B = 0;
   localparam int PC_BF_B   = 1;
   localparam int PC_HS_B   = 2;
   localparam int PC_INTR_A = 3;
   localparam int PC_STB_A  = 4;
   localparam int PC_IBF_A  = 5;
   localparam int PC_ACK_A  = 6;
   localparam int PC_OBF_A  = 7;
endpackage

// File: rtl/ppio_sync.sv
module ppio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 0 || STAGES > 4) begin : g_bad
      $error("ppio_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_flops
      logic [W-1:0] st [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '1;
         end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
         end
      end
      assign q = st[STAGES-1];
   end
endmodule

// File: rtl/ppio_in_chan.sv
module ppio_in_chan #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         stb_n,
   input  logic [W-1:0] din,
   input  logic         rd_hit,
   input  logic         inte,
   output logic [W-1:0] dlat,
   output logic         ibf,
   output logic         intr
);
   if (W < 1) begin : g_bad
      $error("ppio_in_chan: W must be positive");
   end

   logic stb_q;
   wire  stb_rise = en && stb_n && !stb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_q <= 1'b1;
         dlat  <= '0;
         ibf   <= 1'b0;
         intr  <= 1'b0;
      end else if (clr) begin
         stb_q <= stb_n;
         dlat  <= '0;
         ibf   <= 1'b0;
         intr  <= 1'b0;
      end else begin
         stb_q <= stb_n;
         if (en && !stb_n) begin
            dlat <= din;
            ibf  <= 1'b1;
         end else if (rd_hit) begin
            ibf  <= 1'b0;
         end
         if (rd_hit)                     intr <= 1'b0;
         else if (stb_rise && inte && ibf) intr <= 1'b1;
      end
   end

   AST_IBF_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !stb_n && !clr) |=> ibf); // R6
   AST_INTR_NEEDS_IBF: assert property (@(posedge clk) disable iff (!rst_n)
      intr |-> ibf); // R7
   AST_READ_RISE_NO_INTR: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |=> !intr); // R12
endmodule

// File: rtl/ppio_out_chan.sv
module ppio_out_chan (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   input  logic ack_n,
   input  logic wr_hit,
   input  logic inte,
   output logic obf_n,
   output logic intr
);
   logic ack_q;
   wire  ack_rise = en && ack_n && !ack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q <= 1'b1;
         obf_n <= 1'b1;
         intr  <= 1'b0;
      end else if (clr) begin
         ack_q <= ack_n;
         obf_n <= 1'b1;
         intr  <= 1'b0;
      end else begin
         ack_q <= ack_n;
         if (wr_hit)              obf_n <= 1'b0;
         else if (en && !ack_n)   obf_n <= 1'b1;
         if (wr_hit)              intr  <= 1'b0;
         else if (ack_rise && inte) intr <= 1'b1;
      end
   end

   AST_OBF_LOW_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !clr) |=> !obf_n); // R8
   AST_ACK_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !ack_n && !wr_hit && !clr) |=> obf_n); // R8
endmodule

// File: rtl/ppio_top.sv
module ppio_top #(
   parameter int SYNC_STAGES = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs,
   input  logic       rd,
   input  logic       wr,
   input  logic [1:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   input  logic [7:0] pa_in,
   output logic [7:0] pa_out,
   output logic [7:0] pa_oe,
   input  logic [7:0] pb_in,
   output logic [7:0] pb_out,
   output logic [7:0] pb_oe,
   input  logic [7:0] pc_in,
   output logic [7:0] pc_out,
   output logic [7:0] pc_oe
);
   import ppio_pkg::*;
   localparam int W   = PORT_W;
   localparam int NIB = W / 2;

   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad
      $error("ppio_top: SYNC_STAGES must be 0..4");
   end

   ctl_t         ctl;
   logic [W-1:0] pa_lat, pb_lat, pc_lat, inte, pcs;

   wire host_wr = cs && wr;
   wire host_rd = cs && rd;
   wire ctl_wr  = host_wr && (addr == 2'd3) && wdata[7];
   wire bsr_wr  = host_wr && (addr == 2'd3) && !wdata[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl    <= CTL_RESET;
         pa_lat <= '0;
         pb_lat <= '0;
         pc_lat <= '0;
         inte   <= '0;
      end else if (ctl_wr) begin
         ctl    <= ctl_t'(wdata[6:0]);
         pa_lat <= '0;
         pb_lat <= '0;
         pc_lat <= '0;
         inte   <= '0;
      end else begin
         if (host_wr && addr == 2'd0) pa_lat <= wdata;
         if (host_wr && addr == 2'd1) pb_lat <= wdata;
         if (host_wr && addr == 2'd2) pc_lat <= wdata;
         if (bsr_wr) begin
            pc_lat[wdata[3:1]] <= wdata[0];
            inte[wdata[3:1]]   <= wdata[0];
         end
      end
   end

   ppio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pc_in), .q(pcs));

   wire a_m2 = ctl.a_mode[1];
   wire a_m1 = (ctl.a_mode == 2'b01);
   wire b_m1 = ctl.b_mode;

   logic [1:0]   in_en, out_en, stb_n, ack_n, rd_hit, wr_hit, inte_i, inte_o;
   logic [1:0]   ibf, iintr, obf_n, ointr;
   logic [W-1:0] din  [2];
   logic [W-1:0] dlat [2];

   assign in_en  = {b_m1 && ctl.b_in,  a_m2 || (a_m1 && ctl.a_in)};
   assign out_en = {b_m1 && !ctl.b_in, a_m2 || (a_m1 && !ctl.a_in)};
   assign stb_n  = {pcs[PC_HS_B], pcs[PC_STB_A]};
   assign ack_n  = {pcs[PC_HS_B], pcs[PC_ACK_A]};
   assign inte_i = {inte[PC_HS_B], inte[PC_STB_A]};
   assign inte_o = {inte[PC_HS_B], inte[PC_ACK_A]};
   assign din[0] = pa_in;
   assign din[1] = pb_in;

   for (genvar g = 0; g < 2; g++) begin : g_grp
      assign rd_hit[g] = host_rd && (addr == 2'(g)) && in_en[g];
      assign wr_hit[g] = host_wr && (addr == 2'(g)) && out_en[g];

      ppio_in_chan #(.W(W)) u_in (
         .clk(clk), .rst_n(rst_n), .clr(ctl_wr), .en(in_en[g]),
         .stb_n(stb_n[g]), .din(din[g]), .rd_hit(rd_hit[g]),
         .inte(inte_i[g]), .dlat(dlat[g]), .ibf(ibf[g]), .intr(iintr[g]));

      ppio_out_chan u_out (
         .clk(clk), .rst_n(rst_n), .clr(ctl_wr), .en(out_en[g]),
         .ack_n(ack_n[g]), .wr_hit(wr_hit[g]), .inte(inte_o[g]),
         .obf_n(obf_n[g]), .intr(ointr[g]));
   end

   // port C role map: hs_st = status driven out, hs_in = strobe/ack inputs
   logic [W-1:0] hs_st, hs_in, stat, hs, nib_oe, pc_plain, pc_rd, pa_rd, pb_rd;

   always_comb begin
      hs_st = '0;
      hs_in = '0;
      if (b_m1) begin
         hs_st[PC_INTR_B] = 1'b1;
         hs_st[PC_BF_B]   = 1'b1;
         hs_in[PC_HS_B]   = 1'b1;
      end
      if (a_m2) begin
         hs_st[PC_INTR_A] = 1'b1;
         hs_st[PC_IBF_A]  = 1'b1;
         hs_st[PC_OBF_A]  = 1'b1;
         hs_in[PC_STB_A]  = 1'b1;
         hs_in[PC_ACK_A]  = 1'b1;
      end else if (a_m1) begin
         hs_st[PC_INTR_A] = 1'b1;
         if (ctl.a_in) begin
            hs_st[PC_IBF_A] = 1'b1;
            hs_in[PC_STB_A] = 1'b1;
         end else begin
            hs_st[PC_OBF_A] = 1'b1;
            hs_in[PC_ACK_A] = 1'b1;
         end
      end
      stat            = '0;
      stat[PC_INTR_B] = iintr[1] | ointr[1];
      stat[PC_BF_B]   = ctl.b_in ? ibf[1] : obf_n[1];
      stat[PC_INTR_A] = iintr[0] | ointr[0];
      stat[PC_IBF_A]  = ibf[0];
      stat[PC_OBF_A]  = obf_n[0];
   end

   assign hs       = hs_st | hs_in;
   assign nib_oe   = {{NIB{!ctl.cu_in}}, {NIB{!ctl.cl_in}}};
   assign pc_plain = (pc_in & ~nib_oe) | (pc_lat & nib_oe);
   assign pc_rd    = (pc_plain & ~hs) | (stat & hs_st) | (inte & hs_in);
   assign pc_out   = (pc_lat & ~hs) | (stat & hs_st);
   assign pc_oe    = (nib_oe & ~hs) | hs_st;

   assign pa_out = pa_lat;
   assign pb_out = pb_lat;
   assign pa_oe  = a_m2 ? {W{!pcs[PC_ACK_A]}} : {W{!ctl.a_in}};
   assign pb_oe  = {W{!ctl.b_in}};
   assign pa_rd  = in_en[0] ? dlat[0] : (ctl.a_in ? pa_in : pa_lat);
   assign pb_rd  = in_en[1] ? dlat[1] : (ctl.b_in ? pb_in : pb_lat);

   always_comb begin
      case (addr)
         2'd0:    rdata = pa_rd;
         2'd1:    rdata = pb_rd;
         2'd2:    rdata = pc_rd;
         default: rdata = {1'b1, ctl};
      endcase
   end

   AST_MODEWR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> (pa_out == '0 && pb_out == '0)); // R3
   AST_BSR_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      bsr_wr |=> $stable(ctl)); // R4
endmodule

// File: tb/sim_ppio_top.sv
module sim_ppio_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'hFF;
   logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   ppio_top u0 (
      .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
      .wdata(wdata), .rdata(rdata),
      .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
      .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
      .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe));

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      cs = 1'b0; wr = 1'b0;
      #1;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      cs = 1'b1; rd = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      cs = 1'b0; rd = 1'b0;
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=%h exp=%h", 8'h00, 8'h01);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      rd_reg(2'd3, v);
      chk("R1 ctl", v, 8'h9B);
      chk("R1 pa_oe", pa_oe, 8'h00);
      chk("R1 pb_oe", pb_oe, 8'h00);
      chk("R1 pc_oe", pc_oe, 8'h00);
      chk("R1 pa_out", pa_out, 8'h00);

      // R5 / R2: sweep all mode 0 direction combinations
      for (int d = 0; d < 16; d++) begin
         logic [7:0] mw, wa, wb, wc, eoe, erd;
         mw = 8'h80 | (8'(d >> 3 & 1) << 4) | (8'(d >> 2 & 1) << 3)
                    | (8'(d >> 1 & 1) << 1) | 8'(d & 1);
         wa = 8'hC0 + 8'(d); wb = 8'h30 + 8'(d); wc = 8'h69 ^ 8'(d * 7);
         pa_in = 8'h5A ^ 8'(d * 17); pb_in = 8'hA3 ^ 8'(d); pc_in = 8'h3C ^ 8'(d * 9);
         wr_reg(2'd3, mw);
         rd_reg(2'd3, v);
         chk("R2 ctl readback", v, mw);
         wr_reg(2'd0, wa);
         wr_reg(2'd1, wb);
         wr_reg(2'd2, wc);
         chk("R5 pa_oe", pa_oe, mw[4] ? 8'h00 : 8'hFF);
         chk("R5 pb_oe", pb_oe, mw[1] ? 8'h00 : 8'hFF);
         chk("R5 pa_out", pa_out, wa);
         eoe = {mw[3] ? 4'h0 : 4'hF, mw[0] ? 4'h0 : 4'hF};
         chk("R5 pc_oe", pc_oe, eoe);
         chk("R5 pc_out", pc_out, wc);
         erd = (pc_in & ~eoe) | (wc & eoe);
         rd_reg(2'd2, v);
         chk("R5 pc read", v, erd);
         pa_in = ~pa_in;
         rd_reg(2'd0, v);
         chk("R5 pa read", v, mw[4] ? pa_in : wa);
         rd_reg(2'd1, v);
         chk("R5 pb read", v, mw[1] ? pb_in : wb);
      end

      // Mode 1 both outputs: A4
      pc_in = 8'hFF;
      wr_reg(2'd3, 8'hA4);
      chk("R3 pa_out cleared", pa_out, 8'h00);
      chk("R9 pc_oe roles", pc_oe, 8'hBB);
      wr_reg(2'd1, 8'h11);
      chk("R8 obf_b low", pc_out[1], 1'b0);
      // R12: write coincides with ack low
      @(negedge clk);
      pc_in[2] = 1'b0; cs = 1'b1; wr = 1'b1; addr = 2'd1; wdata = 8'h22;
      @(negedge clk);
      pc_in[2] = 1'b1; cs = 1'b0; wr = 1'b0;
      #1;
      chk("R12 obf_b stays low", pc_out[1], 1'b0);
      tick();
      chk("R8 no intr without enable", pc_out[0], 1'b0);
      @(negedge clk); pc_in[2] = 1'b0;
      @(negedge clk); pc_in[2] = 1'b1; #1;
      chk("R8 ack restores obf_b", pc_out[1], 1'b1);
      wr_reg(2'd2, 8'h30);
      chk("R9 pc_out free bits", pc_out, 8'hB2);

      // Mode 1 A input, B mode 0 output: B0
      wr_reg(2'd3, 8'hB0);
      chk("R3 pc_out cleared", pc_out, 8'h00);
      chk("R3 pb_out cleared", pb_out, 8'h00);
      pa_in = 8'h77;
      @(negedge clk); pc_in[4] = 1'b0;
      @(negedge clk); pc_in[4] = 1'b1; #1;
      chk("R6 ibf_a set", pc_out[5], 1'b1);
      tick();
      chk("R7 no intr without enable", pc_out[3], 1'b0);
      pa_in = 8'h11;
      rd_reg(2'd0, v);
      chk("R6 latched data", v, 8'h77);
      chk("R7 read clears ibf", pc_out[5], 1'b0);
      wr_reg(2'd3, 8'h09);
      wr_reg(2'd3, 8'h0F);
      rd_reg(2'd3, v);
      chk("R4 ctl unchanged", v, 8'hB0);
      chk("R4 bsr sets pc7", pc_out[7], 1'b1);
      rd_reg(2'd2, v);
      chk("R4 inte at pc4", v[4], 1'b1);
      @(negedge clk); pc_in[4] = 1'b0;
      @(negedge clk); pc_in[4] = 1'b1;
      tick();
      chk("R7 intr a raised", pc_out[3], 1'b1);
      rd_reg(2'd0, v);
      chk("R7 read clears intr", pc_out[3], 1'b0);
      // R12: read coincides with strobe rising
      @(negedge clk); pc_in[4] = 1'b0;
      @(negedge clk); pc_in[4] = 1'b1; cs = 1'b1; rd = 1'b1; addr = 2'd0;
      @(negedge clk); cs = 1'b0; rd = 1'b0; #1;
      chk("R12 no intr on read+rise", pc_out[3], 1'b0);
      chk("R12 ibf cleared", pc_out[5], 1'b0);

      // Mode 2 on A, mode 1 input on B: C6
      wr_reg(2'd3, 8'hC6);
      wr_reg(2'd3, 8'h0D);
      wr_reg(2'd3, 8'h09);
      wr_reg(2'd3, 8'h05);
      chk("R10 pa_oe idle", pa_oe, 8'h00);
      wr_reg(2'd0, 8'h5A);
      chk("R10 obf_a low", pc_out[7], 1'b0);
      chk("R11 pc_oe roles", pc_oe, 8'hAB);
      @(negedge clk); pc_in[6] = 1'b0; #1;
      chk("R10 pa_oe on ack", pa_oe, 8'hFF);
      chk("R10 pa_out", pa_out, 8'h5A);
      @(negedge clk); pc_in[6] = 1'b1; #1;
      chk("R10 obf_a restored", pc_out[7], 1'b1);
      chk("R10 pa_oe released", pa_oe, 8'h00);
      tick();
      chk("R8 intr after ack", pc_out[3], 1'b1);
      rd_reg(2'd2, v);
      chk("R10 pc status", v, 8'hDC);
      wr_reg(2'd0, 8'h00);
      chk("R8 write clears intr", pc_out[3], 1'b0);
      pa_in = 8'h3C;
      @(negedge clk); pc_in[4] = 1'b0;
      @(negedge clk); pc_in[4] = 1'b1; #1;
      chk("R10 ibf_a", pc_out[5], 1'b1);
      tick();
      chk("R10 input intr", pc_out[3], 1'b1);
      rd_reg(2'd0, v);
      chk("R10 input data", v, 8'h3C);
      chk("R10 intr cleared", pc_out[3], 1'b0);
      pb_in = 8'hA5;
      @(negedge clk); pc_in[2] = 1'b0;
      @(negedge clk); pc_in[2] = 1'b1; #1;
      chk("R11 ibf_b", pc_out[1], 1'b1);
      tick();
      chk("R11 intr_b", pc_out[0], 1'b1);
      rd_reg(2'd1, v);
      chk("R11 pb data", v, 8'hA5);
      chk("R11 cleared", pc_out[1:0], 8'h00);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule